// File: doc/BRIEF.md
# ADC Result FIFO with Threshold Interrupt

This block sits between an analog-to-digital conversion sequencer and whatever drains its results: a bus reader or a DMA engine. Each completed conversion arrives as a one-cycle valid strobe carrying a 12-bit sample and an error flag. While buffering is switched on, the block formats the sample into a 16-bit word and stores it in an eight-entry first-in first-out queue. A reader pops one word per strobe.

A configurable threshold drives a DMA request and an interrupt. Either one asserts once the number of stored words reaches the threshold. Options set at push time do two things: they tag each word with its conversion error, and they reduce the sample to its upper eight bits. Pushing into a full queue and popping from an empty one each set a sticky flag. Software clears these flags with write-one-to-clear strobes.

Top module: `adc_result_fifo`

## Requirements
- R1: A valid strobe is stored only when `cfg_fifo_en` is 1. When it is 0 the strobe is ignored and `level` does not change.
- R2: `level` reports the number of stored words, from 0 to 8. `full` is 1 exactly at 8 and `empty` is 1 exactly at 0.
- R3: Words leave in arrival order. A pop of a non-empty queue places the oldest word on `rd_word` one cycle after the pop edge and lowers `level` by one.
- R4: A stored word carries the sample in bits 11:0 and zeros in bits 14:12. Bit 15 holds the sample's error flag when `cfg_err_tag` is 1, and is 0 otherwise.
- R5: When `cfg_shift8` is 1 at push time, bits 7:0 of the word hold sample bits 11:4 and bits 11:8 are zero. Bit 15 still follows R4.
- R6: A push while full with no pop in the same cycle discards the new sample. The stored words and `level` stay unchanged, and `over_flag` sets.
- R7: A pop while empty returns 0 on `rd_word`, leaves `level` at 0 and sets `under_flag`.
- R8: `over_flag` and `under_flag` stay set until their clear strobes (`clr_over`, `clr_under`). A new set event in the same cycle as a clear wins.
- R9: `irq_raw` is 1 exactly when `level` >= `cfg_thresh`. `dreq` is `irq_raw` AND `cfg_dreq_en`. Both follow `level` in the same cycle.
- R10: `irq_status` equals (`irq_raw` AND `cfg_irq_en`) OR `cfg_irq_force`.
- R11: After reset, `level` is 0, `empty` is 1, `full` is 0, both sticky flags are 0 and `rd_word` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | Conversion result strobe |
| wr_sample | input | 12 | Conversion sample |
| wr_err | input | 1 | Conversion error flag of this sample |
| rd_pop | input | 1 | Pop strobe |
| rd_word | output | 16 | Formatted word from the last pop |
| cfg_fifo_en | input | 1 | Store results when 1 |
| cfg_err_tag | input | 1 | Put the error flag in bit 15 |
| cfg_shift8 | input | 1 | Keep only the upper 8 sample bits |
| cfg_dreq_en | input | 1 | DMA request enable |
| cfg_thresh | input | 4 | Level threshold |
| cfg_irq_en | input | 1 | Interrupt mask enable |
| cfg_irq_force | input | 1 | Interrupt force |
| clr_over | input | 1 | Clear the overflow flag |
| clr_under | input | 1 | Clear the underflow flag |
| level | output | 4 | Stored word count |
| full | output | 1 | Queue holds 8 words |
| empty | output | 1 | Queue holds no word |
| over_flag | output | 1 | Sticky overflow |
| under_flag | output | 1 | Sticky underflow |
| dreq | output | 1 | DMA request |
| irq_raw | output | 1 | Raw threshold interrupt |
| irq_status | output | 1 | Masked and forced interrupt |

## Verification
The storage state, the flags and `rd_word` are registered, so each of them shows the effect of a strobe one cycle after the edge that captures it. The bench drives its inputs on the falling edge and checks these outputs on the next falling edge. `dreq`, `irq_raw` and `irq_status` are combinational from the registered `level` and the configuration inputs. At every level from 0 to 8, the bench sweeps all sixteen thresholds and all eight enable and force combinations. Each setting is checked a few picoseconds after it is applied, and the whole sweep finishes within the same low half-period, before the next rising edge.

// File: rtl/adc_fifo_pkg.sv
package adc_fifo_pkg;
    localparam int SAMPLE_W = 12;
    localparam int WORD_W   = 16;
    localparam int SHIFT_N  = 4;

    typedef struct packed {
        logic                dreq;
        logic                raw;
        logic                status;
    } irq_out_t;
endpackage

// File: rtl/adc_fifo_fmt.sv
module adc_fifo_fmt #(
    parameter int SAMPLE_W = 12,
    parameter int WORD_W   = 16,
    parameter int SHIFT_N  = 4
) (
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                err,
    input  logic                tag_en,
    input  logic                shift_en,
    output logic [WORD_W-1:0]   word
);
    logic [SAMPLE_W-1:0] body;

    generate
        if (SHIFT_N > 0) begin : g_shift
            always_comb body = shift_en ? (sample >> SHIFT_N) : sample;
        end else begin : g_noshift
            always_comb body = sample;
        end
    endgenerate

    always_comb begin
        word                 = '0;
        word[SAMPLE_W-1:0]   = body;
        word[WORD_W-1]       = tag_en & err;
    end
endmodule

// File: rtl/adc_fifo_store.sv
module adc_fifo_store #(
    parameter int DEPTH   = 8,
    parameter int WORD_W  = 16,
    parameter int LEVEL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               push,
    input  logic               pop,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               clr_over,
    input  logic               clr_under,
    output logic [WORD_W-1:0]  rdata,
    output logic [LEVEL_W-1:0] level,
    output logic               full,
    output logic               empty,
    output logic               over,
    output logic               under
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LEVEL_W-1:0] DEPTH_L = LEVEL_W'(DEPTH);
    localparam logic [PTR_W-1:0]   LAST_P  = PTR_W'(DEPTH - 1);

    typedef struct packed {
        logic [PTR_W-1:0]   wr_ptr;
        logic [PTR_W-1:0]   rd_ptr;
        logic [LEVEL_W-1:0] count;
        logic [WORD_W-1:0]  rdata;
        logic               over;
        logic               under;
    } st_t;

    st_t               st_d, st_q;
    logic [WORD_W-1:0] mem_d [DEPTH];
    logic [WORD_W-1:0] mem_q [DEPTH];
    logic              is_full, is_empty, do_pop, do_push;

    function automatic logic [PTR_W-1:0] adv(input logic [PTR_W-1:0] p);
        return (p == LAST_P) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d     = st_q;
        mem_d    = mem_q;
        is_full  = (st_q.count == DEPTH_L);
        is_empty = (st_q.count == '0);
        do_pop   = pop && !is_empty;
        do_push  = push && (!is_full || do_pop);

        if (do_pop) begin
            st_d.rdata  = mem_q[st_q.rd_ptr];
            st_d.rd_ptr = adv(st_q.rd_ptr);
        end else if (pop) begin
            st_d.rdata  = '0;
        end

        if (do_push) begin
            mem_d[st_q.wr_ptr] = wdata;
            st_d.wr_ptr        = adv(st_q.wr_ptr);
        end

        case ({do_push, do_pop})
            2'b10:   st_d.count = st_q.count + 1'b1;
            2'b01:   st_d.count = st_q.count - 1'b1;
            default: st_d.count = st_q.count;
        endcase

        if (clr_over)                      st_d.over  = 1'b0;
        if (push && is_full && !do_pop)    st_d.over  = 1'b1;
        if (clr_under)                     st_d.under = 1'b0;
        if (pop && is_empty)               st_d.under = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_mem
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) mem_q[i] <= '0;
                else        mem_q[i] <= mem_d[i];
            end
        end
    endgenerate

    assign rdata = st_q.rdata;
    assign level = st_q.count;
    assign full  = (st_q.count == DEPTH_L);
    assign empty = (st_q.count == '0);
    assign over  = st_q.over;
    assign under = st_q.under;
endmodule

// File: rtl/adc_fifo_irq.sv
module adc_fifo_irq #(
    parameter int LEVEL_W = 4
) (
    input  logic [LEVEL_W-1:0] level,
    input  logic [LEVEL_W-1:0] thresh,
    input  logic               dreq_en,
    input  logic               irq_en,
    input  logic               irq_force,
    output adc_fifo_pkg::irq_out_t irq_o
);
    always_comb begin
        irq_o.raw    = (level >= thresh);
        irq_o.dreq   = irq_o.raw & dreq_en;
        irq_o.status = (irq_o.raw & irq_en) | irq_force;
    end
endmodule

// File: rtl/adc_result_fifo.sv
module adc_result_fifo #(
    parameter int DEPTH    = 8,
    parameter int SAMPLE_W = adc_fifo_pkg::SAMPLE_W,
    parameter int WORD_W   = adc_fifo_pkg::WORD_W,
    parameter int SHIFT_N  = adc_fifo_pkg::SHIFT_N,
    localparam int LEVEL_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_valid,
    input  logic [SAMPLE_W-1:0] wr_sample,
    input  logic                wr_err,
    input  logic                rd_pop,
    output logic [WORD_W-1:0]   rd_word,
    input  logic                cfg_fifo_en,
    input  logic                cfg_err_tag,
    input  logic                cfg_shift8,
    input  logic                cfg_dreq_en,
    input  logic [LEVEL_W-1:0]  cfg_thresh,
    input  logic                cfg_irq_en,
    input  logic                cfg_irq_force,
    input  logic                clr_over,
    input  logic                clr_under,
    output logic [LEVEL_W-1:0]  level,
    output logic                full,
    output logic                empty,
    output logic                over_flag,
    output logic                under_flag,
    output logic                dreq,
    output logic                irq_raw,
    output logic                irq_status
);
    logic [WORD_W-1:0]       fmt_word;
    logic                    push_req;
    adc_fifo_pkg::irq_out_t  irq_w;

    assign push_req = wr_valid & cfg_fifo_en;

    adc_fifo_fmt #(
        .SAMPLE_W (SAMPLE_W),
        .WORD_W   (WORD_W),
        .SHIFT_N  (SHIFT_N)
    ) u_fmt (
        .sample   (wr_sample),
        .err      (wr_err),
        .tag_en   (cfg_err_tag),
        .shift_en (cfg_shift8),
        .word     (fmt_word)
    );

    adc_fifo_store #(
        .DEPTH   (DEPTH),
        .WORD_W  (WORD_W),
        .LEVEL_W (LEVEL_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .pop       (rd_pop),
        .wdata     (fmt_word),
        .clr_over  (clr_over),
        .clr_under (clr_under),
        .rdata     (rd_word),
        .level     (level),
        .full      (full),
        .empty     (empty),
        .over      (over_flag),
        .under     (under_flag)
    );

    adc_fifo_irq #(
        .LEVEL_W (LEVEL_W)
    ) u_irq (
        .level     (level),
        .thresh    (cfg_thresh),
        .dreq_en   (cfg_dreq_en),
        .irq_en    (cfg_irq_en),
        .irq_force (cfg_irq_force),
        .irq_o     (irq_w)
    );

    assign dreq       = irq_w.dreq;
    assign irq_raw    = irq_w.raw;
    assign irq_status = irq_w.status;
endmodule

// File: rtl/adc_result_fifo_chk.sv
module adc_result_fifo_chk #(
    parameter int DEPTH    = 8,
    parameter int SAMPLE_W = 12,
    parameter int WORD_W   = 16,
    localparam int LEVEL_W = $clog2(DEPTH + 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_valid,
    input logic                rd_pop,
    input logic [WORD_W-1:0]   rd_word,
    input logic                cfg_fifo_en,
    input logic                cfg_irq_force,
    input logic                clr_over,
    input logic [LEVEL_W-1:0]  level,
    input logic                full,
    input logic                empty,
    input logic                over_flag,
    input logic                under_flag,
    input logic                dreq,
    input logic                irq_raw,
    input logic                irq_status
);
    localparam logic [LEVEL_W-1:0] DEPTH_L = LEVEL_W'(DEPTH);

    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= DEPTH_L);

    p_full_not_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(full && empty));

    p_disabled_ignored_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_fifo_en && !rd_pop) |=> (level == $past(level)));

    p_pop_drops_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && !empty && !(wr_valid && cfg_fifo_en)) |=> (level == $past(level) - 1'b1));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && cfg_fifo_en && full && !rd_pop) |=> (over_flag && level == $past(level)));

    p_underflow_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_pop && empty) |=> (rd_word == '0 && under_flag));

    p_over_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (over_flag && !clr_over) |=> over_flag);

    p_dreq_needs_raw_r9: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> irq_raw);

    p_force_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_irq_force |-> irq_status);
endmodule

bind adc_result_fifo adc_result_fifo_chk #(
    .DEPTH    (DEPTH),
    .SAMPLE_W (SAMPLE_W),
    .WORD_W   (WORD_W)
) u_chk (.*);

// File: tb/adc_result_fifo_bench.sv
`timescale 1ns/1ps
module adc_result_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid = 1'b0;
    logic [11:0] wr_sample = '0;
    logic        wr_err = 1'b0;
    logic        rd_pop = 1'b0;
    logic [15:0] rd_word;
    logic        cfg_fifo_en = 1'b0, cfg_err_tag = 1'b0, cfg_shift8 = 1'b0;
    logic        cfg_dreq_en = 1'b0, cfg_irq_en = 1'b0, cfg_irq_force = 1'b0;
    logic [3:0]  cfg_thresh = '0;
    logic        clr_over = 1'b0, clr_under = 1'b0;
    logic [3:0]  level;
    logic        full, empty, over_flag, under_flag, dreq, irq_raw, irq_status;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] q [8];
    int          cnt = 0;
    logic        e_over = 1'b0, e_under = 1'b0;

    always #10 clk = ~clk;

    adc_result_fifo u_adc_result_fifo (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] fmt(input logic [11:0] s, input logic e,
                                        input logic tag, input logic sh);
        logic [15:0] w = '0;
        w[11:0] = sh ? {4'b0000, s[11:4]} : s;
        w[15]   = tag & e;
        return w;
    endfunction

    task automatic chk_state(input string req);
        chk({req, " level"}, 32'(level), 32'(cnt));
        chk({req, " full"},  32'(full),  32'(cnt == 8));
        chk({req, " empty"}, 32'(empty), 32'(cnt == 0));
        chk({req, " over"},  32'(over_flag),  32'(e_over));
        chk({req, " under"}, 32'(under_flag), 32'(e_under));
    endtask

    // R9 R10: all thresholds and enable/force settings at the current level
    task automatic sweep_irq();
        for (int t = 0; t < 16; t++) begin
            for (int m = 0; m < 8; m++) begin
                logic rw;
                cfg_thresh = 4'(t);
                cfg_dreq_en = m[0]; cfg_irq_en = m[1]; cfg_irq_force = m[2];
                #0.005;
                rw = (cnt >= t);
                chk("R9 irq_raw", 32'(irq_raw), 32'(rw));
                chk("R9 dreq", 32'(dreq), 32'(rw & m[0]));
                chk("R10 irq_status", 32'(irq_status), 32'((rw & m[1]) | m[2]));
            end
        end
        cfg_thresh = '0; cfg_dreq_en = 1'b0; cfg_irq_en = 1'b0; cfg_irq_force = 1'b0;
    endtask

    task automatic do_push(input logic [11:0] s, input logic e);
        wr_valid = 1'b1; wr_sample = s; wr_err = e;
        @(negedge clk);
        wr_valid = 1'b0;
        if (cfg_fifo_en) begin
            if (cnt < 8) begin
                q[cnt] = fmt(s, e, cfg_err_tag, cfg_shift8);
                cnt++;
            end else begin
                e_over = 1'b1;
            end
        end
    endtask

    task automatic do_pop(input string req);
        logic [15:0] exp;
        rd_pop = 1'b1;
        @(negedge clk);
        rd_pop = 1'b0;
        if (cnt > 0) begin
            exp = q[0];
            for (int k = 0; k < 7; k++) q[k] = q[k+1];
            cnt--;
        end else begin
            exp = '0;
            e_under = 1'b1;
        end
        chk({req, " rd_word"}, 32'(rd_word), 32'(exp));
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R11: reset state
        chk_state("R11");
        chk("R11 rd_word", 32'(rd_word), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_state("R11");

        // R1: strobes ignored with buffering off
        for (int i = 0; i < 3; i++) begin
            do_push(12'h123 + 12'(i), 1'b1);
            chk_state("R1");
        end

        // R2 R4: fill with error tagging on, sweeping interrupts at every level
        cfg_fifo_en = 1'b1; cfg_err_tag = 1'b1;
        sweep_irq();
        for (int i = 0; i < 8; i++) begin
            do_push(12'((i * 12'h1A7 + 5) & 12'hFFF), i[0]);
            chk_state("R2");
            sweep_irq();
        end

        // R6: push while full is dropped
        do_push(12'hABC, 1'b1);
        chk_state("R6");
        // R8: flag stays set
        repeat (3) @(negedge clk);
        chk_state("R8 sticky");

        // R3 R4: drain in order
        for (int i = 0; i < 8; i++) begin
            do_pop("R3");
            chk_state("R3");
            sweep_irq();
        end

        // R4: tagging off clears bit 15
        cfg_err_tag = 1'b0;
        do_push(12'hFED, 1'b1);
        do_pop("R4 untagged");

        // R7: pop while empty
        do_pop("R7");
        chk_state("R7");

        // R8: set wins over clear in the same cycle
        clr_under = 1'b1;
        do_pop("R8 set-wins");
        clr_under = 1'b0;
        chk_state("R8 set-wins");

        // R8: clear strobes
        clr_under = 1'b1; clr_over = 1'b1;
        @(negedge clk);
        clr_under = 1'b0; clr_over = 1'b0;
        e_under = 1'b0; e_over = 1'b0;
        chk_state("R8 clear");

        // R5: shift mode across samples, tagging off and on
        cfg_shift8 = 1'b1;
        for (int tg = 0; tg < 2; tg++) begin
            cfg_err_tag = tg[0];
            for (int i = 0; i < 16; i++) begin
                do_push(12'((i * 12'h111) ^ 12'h0F3), i[1]);
                do_pop("R5");
            end
        end
        chk_state("R5");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule